// File: doc/BRIEF.md
# Two-Pattern Scan Chain with Per-Bit Hold Stage

This block is a parameterised scan chain for launching and capturing delay tests on a piece of combinational logic. Each scan flop has a hold stage between it and the state line that goes to the logic. While the hold input is low, the stage is transparent and the logic sees the flop contents. While hold is high, the stage freezes, so the logic keeps its first vector steady while the chain underneath is reloaded.

A test runs like this. The tester shifts the first vector into the chain with hold low and lets the logic settle on it. It raises hold and shifts the second vector in behind it. It then drops hold, which applies the second vector to the logic at once. One clock later, with the test-control input in normal mode, the flops capture the logic's response. The tester then returns to scan mode and shifts the response out.

The length of the chain is the parameter `N`. A synchronous active-low reset clears both the flops and the hold stage.

Top module: `esc_chain_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every flop and hold stage is cleared, so `state_o` and `scan_out` read 0 after that edge.
- R2: When `test_ctl` is 1 (scan) at a rising edge, bit 0 takes `scan_in` and each bit i takes the old bit i-1. `scan_out` always shows bit N-1.
- R3: When `test_ctl` is 0 (normal) at a rising edge, every bit i of the chain loads `capt_i[i]`.
- R4: While `hold` is 0, `state_o` equals the current chain contents.
- R5: While `hold` is 1, `state_o` shows the chain contents as of the last rising edge at which `hold` was sampled 0 (or the last reset). Shifting under hold does not disturb `state_o`.
- R6: When `hold` falls, `state_o` shows the chain contents in the same cycle, without waiting for a clock edge.
- R7: A capture taken while `hold` is 1 updates the chain and `scan_out` but leaves `state_o` unchanged.
- R8: In the two-pattern sequence, the normal-mode edge that follows the release of hold stores the `capt_i` value present at that edge. That response can then be shifted out serially, bit N-1 first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| test_ctl | input | 1 | 1 = scan shift, 0 = normal capture |
| hold | input | 1 | 1 freezes the state lines, 0 makes them transparent |
| scan_in | input | 1 | Serial data into bit 0 |
| capt_i | input | N | Response from the logic under test |
| state_o | output | N | State lines driven to the logic under test |
| scan_out | output | 1 | Serial data out of bit N-1 |

## Verification
The hardest situation to reach is a chain that differs from the frozen state lines: a full second vector shifted in under hold, followed by a capture in the single cycle after hold is released. Random stimulus seldom holds `hold` high for N shifts in a row. A directed sequence therefore loads V1, shifts a different V2 under hold, and checks that `state_o` still shows V1. It then releases hold and checks V2 combinationally, captures, and shifts the response out bit by bit. Random cycles with a fixed seed then mix hold, mode and data freely against a bench model, including captures made under hold.

// File: rtl/esc_pkg.sv
package esc_pkg;
    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_SCAN   = 1'b1
    } esc_mode_e;
endpackage

// File: rtl/esc_shift_bank.sv
module esc_shift_bank #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         test_ctl,
    input  logic         scan_in,
    input  logic [N-1:0] capt_i,
    output logic [N-1:0] chain_d,
    output logic [N-1:0] chain_q
);
    import esc_pkg::*;

    localparam int LAST = N - 1;

    typedef struct packed {
        logic [LAST:0] bits;
    } bank_t;

    bank_t     bank_d;
    bank_t     bank_q;
    esc_mode_e mode;

    assign mode = esc_mode_e'(test_ctl);

    always_comb begin
        bank_d = bank_q;
        if (!rst_n) begin
            bank_d.bits = '0;
        end else if (mode == MODE_SCAN) begin
            bank_d.bits = {bank_q.bits[LAST-1:0], scan_in};
        end else begin
            bank_d.bits = capt_i;
        end
    end

    always_ff @(posedge clk) begin
        bank_q <= bank_d;
    end

    assign chain_d = bank_d.bits;
    assign chain_q = bank_q.bits;
endmodule

// File: rtl/esc_hold_bank.sv
module esc_hold_bank #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic [N-1:0] chain_d,
    input  logic [N-1:0] chain_q,
    output logic [N-1:0] state_o
);
    for (genvar g = 0; g < N; g++) begin : g_cell
        typedef struct packed {
            logic held;
        } cell_t;

        cell_t cell_d;
        cell_t cell_q;

        always_comb begin
            cell_d = cell_q;
            if (!rst_n) begin
                cell_d.held = 1'b0;
            end else if (!hold) begin
                cell_d.held = chain_d[g];
            end
        end

        always_ff @(posedge clk) begin
            cell_q <= cell_d;
        end

        assign state_o[g] = hold ? cell_q.held : chain_q[g];
    end
endmodule

// File: rtl/esc_chain_top.sv
module esc_chain_top #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         test_ctl,
    input  logic         hold,
    input  logic         scan_in,
    input  logic [N-1:0] capt_i,
    output logic [N-1:0] state_o,
    output logic         scan_out
);
    logic [N-1:0] chain_d;
    logic [N-1:0] chain_q;

    esc_shift_bank #(.N(N)) i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .test_ctl (test_ctl),
        .scan_in  (scan_in),
        .capt_i   (capt_i),
        .chain_d  (chain_d),
        .chain_q  (chain_q)
    );

    esc_hold_bank #(.N(N)) i_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold),
        .chain_d (chain_d),
        .chain_q (chain_q),
        .state_o (state_o)
    );

    assign scan_out = chain_q[N-1];
endmodule

// File: rtl/esc_chain_chk.sv
module esc_chain_chk #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         test_ctl,
    input logic         hold,
    input logic         scan_in,
    input logic [N-1:0] capt_i,
    input logic [N-1:0] chain_q,
    input logic [N-1:0] state_o,
    input logic         scan_out
);
    // R1: a reset edge clears the outputs
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (hold || state_o == '0) && scan_out == 1'b0);

    // R2: a scan edge shifts by one position
    a_r2_shift: assert property (@(posedge clk) disable iff (!rst_n)
        test_ctl |=> chain_q == {$past(chain_q[N-2:0]), $past(scan_in)});

    // R2: the serial output is the last bit
    a_r2_scan_out: assert property (@(posedge clk) disable iff (!rst_n)
        scan_out == chain_q[N-1]);

    // R3: a normal edge loads the capture input
    a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !test_ctl |=> chain_q == $past(capt_i));

    // R4: the state lines are transparent while hold is low
    a_r4_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |-> state_o == chain_q);

    // R5: the state lines stay frozen while hold stays high
    a_r5_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (!hold || $stable(state_o)));
endmodule

bind esc_chain_top esc_chain_chk #(.N(N)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .test_ctl (test_ctl),
    .hold     (hold),
    .scan_in  (scan_in),
    .capt_i   (capt_i),
    .chain_q  (chain_q),
    .state_o  (state_o),
    .scan_out (scan_out)
);

// File: tb/test_esc_chain_top.sv
module test_esc_chain_top;
    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         test_ctl = 1'b1;
    logic         hold = 1'b0;
    logic         scan_in = 1'b0;
    logic [N-1:0] capt_i = '0;
    logic [N-1:0] state_o;
    logic         scan_out;

    int total = 0;
    int bad = 0;
    logic [N-1:0] m_ff = '0;
    logic [N-1:0] m_hq = '0;

    always #2.5 clk = ~clk;

    esc_chain_top #(.N(N)) i_esc_chain_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .test_ctl (test_ctl),
        .hold     (hold),
        .scan_in  (scan_in),
        .capt_i   (capt_i),
        .state_o  (state_o),
        .scan_out (scan_out)
    );

    function automatic logic [N-1:0] next_ff(logic [N-1:0] ff, logic rn, logic tc,
                                             logic si, logic [N-1:0] cap);
        if (!rn) return '0;
        if (tc) return {ff[N-2:0], si};
        return cap;
    endfunction

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive inputs just after a falling edge, check the combinational
    // outputs, then advance the bench model across the rising edge.
    task automatic cycle(logic tc, logic h, logic si, logic [N-1:0] cap, logic do_chk);
        test_ctl = tc; hold = h; scan_in = si; capt_i = cap;
        #1;
        if (do_chk) begin
            check(h ? "R5" : "R4", state_o, h ? m_hq : m_ff);
            check("R2", {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, m_ff[N-1]});
        end
        @(posedge clk);
        m_ff = next_ff(m_ff, rst_n, tc, si, cap);
        if (!rst_n) m_hq = '0;
        else if (!h) m_hq = m_ff;
        @(negedge clk);
    endtask

    logic done = 1'b0;
    initial begin
        #(200000 * 5);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] v1, v2, resp, seen;
        int unused;
        unused = $urandom(32'h5eed_0042);
        @(negedge clk);
        // load junk, then reset
        for (int i = 0; i < 4; i++) cycle(1'b1, 1'b0, 1'b1, '1, 1'b0);
        rst_n = 1'b0;
        cycle(1'b1, 1'b0, 1'b1, '1, 1'b0);
        cycle(1'b0, 1'b0, 1'b0, '1, 1'b0);
        check("R1", state_o, '0);
        check("R1", {{(N-1){1'b0}}, scan_out}, '0);
        rst_n = 1'b1;

        // directed two-pattern sequence
        v1 = 16'hA5C3; v2 = 16'h3C5A; resp = 16'hD00F;
        for (int i = N - 1; i >= 0; i--) cycle(1'b1, 1'b0, v1[i], '0, 1'b1);
        check("R4", state_o, v1);
        for (int i = N - 1; i >= 0; i--) cycle(1'b1, 1'b1, v2[i], '0, 1'b1);
        hold = 1'b1; #1;
        check("R5", state_o, v1);
        hold = 1'b0; #1;
        check("R6", state_o, v2);
        cycle(1'b0, 1'b0, 1'b0, resp, 1'b0);
        check("R8", state_o, resp);
        seen = '0;
        for (int i = N - 1; i >= 0; i--) begin
            test_ctl = 1'b1; #1;
            seen[i] = scan_out;
            cycle(1'b1, 1'b1, 1'b0, '0, 1'b0);
        end
        check("R8", seen, resp);

        // capture under hold: state lines untouched, scan_out updated
        hold = 1'b0; #1;
        cycle(1'b1, 1'b0, 1'b0, '0, 1'b1);
        v1 = state_o;
        cycle(1'b0, 1'b1, 1'b0, 16'h8001, 1'b1);
        hold = 1'b1; #1;
        check("R7", state_o, v1);
        check("R7", {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, 1'b1});
        cycle(1'b1, 1'b1, 1'b0, '0, 1'b1);
        hold = 1'b0; #1;
        check("R3", state_o, {16'h8001} << 1);

        // random mix
        for (int k = 0; k < 3000; k++) begin
            cycle(1'($urandom % 4 != 0), 1'($urandom % 3 == 0), 1'($urandom),
                  N'($urandom), 1'b1);
        end
        check("R3", state_o, hold ? m_hq : m_ff);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule